// File: doc/BRIEF.md
# Slave-Mode Serial Audio Transmitter with Per-Edge Word Alignment

This block drives the data line of a two-channel serial audio link whose bit clock and word-select line come from an external master. Both clocks are treated as asynchronous inputs. They are brought into the system clock domain and watched for edges there. Word select is sampled when the bit clock rises. The data line is updated after the bit clock falls.

Each change of word select opens a new channel slot. The bit period right after the change is a delay bit. The next sixteen bit periods carry the sample, most significant bit first. After that the line is held at zero until the next change, however many bit clocks the master puts in the slot. Every word is therefore aligned to its own word-select edge. The right-channel word never runs straight on from the left one.

Samples come in as left/right pairs through a one-entry holding register with a valid/ready handshake. `in_ready` is high exactly when the holding register is empty, and it does not depend on `in_valid`. A pair moves across when both are high on a system clock edge. While the register is full, `in_ready` is low and the source has to wait. The register is emptied at the start of each left slot, when its pair moves into the shadow that feeds both slots of that frame.

Top module: `i2s_slave_tx`

## Requirements
- R1: After reset, `sdata` is 0, `in_ready` is 1 and both error flags are 0. `sdata` stays 0 until a high-to-low change of word select has been sampled, so transmission always begins with a left slot.
- R2: The first bit period after a word-select change carries the delay bit. It is 0 when the previous slot was at least 17 bit clocks long. When the previous slot was shorter, it carries the bit that slot would have sent next.
- R3: The 16-bit word goes out most significant bit first in bit periods 1 to 16 after the change. Word select low (0) carries the left sample and word select high (1) carries the right sample.
- R4: From bit period 17 until the next word-select change, `sdata` is 0, for slot lengths of 17, 21 and 32 bit clocks.
- R5: Each channel word restarts at its own word-select edge. The right word begins only after the low-to-high change, whatever the length of the left slot.
- R6: A slot shorter than 17 bit clocks cuts the word off at the next change, and the next word starts normally. `err_short` is set and stays set until reset. The slot that ends before the first left slot is not judged.
- R7: `in_ready` equals "holding register empty". A transfer happens on a clock edge with `in_valid` and `in_ready` both high. `in_ready` is low on the next cycle and stays low until the next left-slot start.
- R8: At each left-slot start, the held pair is copied to the shadow. The left and right slots of that frame both send that same pair.
- R9: If the holding register is empty at a left-slot start, the previous pair is sent again in both slots, and `err_underrun` is set and stays set until reset.
- R10: `sdata` changes only in response to a falling bit-clock edge, SYNC_STAGES+1 system clocks after that edge. Each bit-clock half period must be longer than this delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bit clock from the external master |
| ws | input | 1 | Word select from the external master (0 left, 1 right) |
| sdata | output | 1 | Serial data line |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding register empty |
| in_left | input | WORD_W | Left sample of the offered pair |
| in_right | input | WORD_W | Right sample of the offered pair |
| err_short | output | 1 | Sticky: a slot was shorter than WORD_W+1 bit clocks |
| err_underrun | output | 1 | Sticky: no pair was held at a left-slot start |

## Verification
The bench uses the default parameters: 16-bit words and a two-stage synchronizer. Its master model runs the bit clock at twelve system clocks per period, which keeps each half period longer than the three-cycle path from a bit-clock edge to a change on `sdata`. Because slot length is chosen at run time, one build covers slots of 12, 16, 17, 21 and 32 bit clocks. That range includes truncation, a least significant bit that lands in the next slot's delay bit, and long zero padding. Withholding a pair drives the shadow-repeat path.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;

  // Channel carried by a slot, as given by the sampled word-select level.
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

endpackage

// File: rtl/i2s_tx_sync_edge.sv
`timescale 1ns/1ps
// Brings the master's bit clock and word select into the system domain and
// reports falling bit-clock edges and word-select changes (sampled at rises).
module i2s_tx_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_async,
  input  logic                ws_async,
  output logic                bclk_fall,
  output logic                slot_edge,
  output i2s_tx_pkg::chan_e   slot_chan
);
  import i2s_tx_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] bclk_sh;
  logic [LAST:0] ws_sh;
  logic          bclk_s;
  logic          ws_s;
  logic          bclk_d;
  logic          ws_last;
  logic          ws_seen;
  logic          bclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_sh <= '0;
      ws_sh   <= '0;
    end else begin
      bclk_sh[0] <= bclk_async;
      ws_sh[0]   <= ws_async;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        bclk_sh[i] <= bclk_sh[i-1];
        ws_sh[i]   <= ws_sh[i-1];
      end
    end
  end

  assign bclk_s = bclk_sh[LAST];
  assign ws_s   = ws_sh[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d  <= 1'b0;
      ws_last <= 1'b0;
      ws_seen <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      if (bclk_rise) begin
        ws_last <= ws_s;
        ws_seen <= 1'b1;
      end
    end
  end

  assign bclk_rise = bclk_s & ~bclk_d;
  assign bclk_fall = ~bclk_s & bclk_d;
  assign slot_edge = bclk_rise & ws_seen & (ws_s != ws_last);
  assign slot_chan = ws_s ? CH_RIGHT : CH_LEFT;

endmodule

// File: rtl/i2s_tx_pair_hold.sv
`timescale 1ns/1ps
// One-entry holding register plus the frame shadow that feeds both slots.
module i2s_tx_pair_hold #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  input  logic              take,
  output logic              in_ready,
  output logic              hold_full,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word,
  output logic              err_underrun
);
  logic [WORD_W-1:0] hold_l;
  logic [WORD_W-1:0] hold_r;
  logic [WORD_W-1:0] shad_l;
  logic [WORD_W-1:0] shad_r;
  logic              full;
  logic              accept;

  assign accept = in_valid & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l       <= '0;
      hold_r       <= '0;
      shad_l       <= '0;
      shad_r       <= '0;
      full         <= 1'b0;
      err_underrun <= 1'b0;
    end else begin
      if (take) begin
        if (full) begin
          shad_l <= hold_l;
          shad_r <= hold_r;
          full   <= 1'b0;
        end else begin
          err_underrun <= 1'b1;
        end
      end
      if (accept) begin
        hold_l <= in_left;
        hold_r <= in_right;
        full   <= 1'b1;
      end
    end
  end

  assign in_ready   = ~full;
  assign hold_full  = full;
  // The left word loads in the same cycle as the take, so it is picked
  // from the holding register directly; the right word reads the shadow.
  assign left_word  = full ? hold_l : shad_l;
  assign right_word = shad_r;

endmodule

// File: rtl/i2s_tx_shifter.sv
`timescale 1ns/1ps
// Slot bit counter and output shift register.
module i2s_tx_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_fall,
  input  logic              slot_edge,
  input  logic              slot_left,
  input  logic [WORD_W-1:0] left_word,
  input  logic [WORD_W-1:0] right_word,
  output logic              sdata,
  output logic              started,
  output logic              err_short
);
  localparam int CNT_LIMIT = WORD_W + 1;
  localparam int CNT_W     = $clog2(CNT_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(CNT_LIMIT);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sreg;
  logic              load;

  assign load = slot_edge & (started | slot_left);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= CNT_MAX;
      sreg      <= '0;
      sdata     <= 1'b0;
      started   <= 1'b0;
      err_short <= 1'b0;
    end else begin
      if (load) begin
        if (started && (cnt < CNT_MAX)) begin
          err_short <= 1'b1;
        end
        started <= 1'b1;
        cnt     <= '0;
        sreg    <= slot_left ? left_word : right_word;
      end else if (bclk_fall && started) begin
        if (cnt < CNT_DATA) begin
          sdata <= sreg[WORD_W-1];
          sreg  <= {sreg[WORD_W-2:0], 1'b0};
        end else begin
          sdata <= 1'b0;
        end
        if (cnt < CNT_MAX) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/i2s_slave_tx.sv
`timescale 1ns/1ps
module i2s_slave_tx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              ws,
  output logic              sdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  output logic              err_short,
  output logic              err_underrun
);
  import i2s_tx_pkg::*;

  logic              bclk_fall;
  logic              slot_edge;
  chan_e             slot_chan;
  logic              slot_left;
  logic              left_start;
  logic              started;
  logic              hold_full;
  logic [WORD_W-1:0] left_word;
  logic [WORD_W-1:0] right_word;

  i2s_tx_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_async(bclk),
    .ws_async  (ws),
    .bclk_fall (bclk_fall),
    .slot_edge (slot_edge),
    .slot_chan (slot_chan)
  );

  assign slot_left  = (slot_chan == CH_LEFT);
  assign left_start = slot_edge & slot_left;

  i2s_tx_pair_hold #(.WORD_W(WORD_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_left     (in_left),
    .in_right    (in_right),
    .take        (left_start),
    .in_ready    (in_ready),
    .hold_full   (hold_full),
    .left_word   (left_word),
    .right_word  (right_word),
    .err_underrun(err_underrun)
  );

  i2s_tx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_fall (bclk_fall),
    .slot_edge (slot_edge),
    .slot_left (slot_left),
    .left_word (left_word),
    .right_word(right_word),
    .sdata     (sdata),
    .started   (started),
    .err_short (err_short)
  );

endmodule

// File: rtl/i2s_slave_tx_chk.sv
`timescale 1ns/1ps
module i2s_slave_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic sdata,
  input logic in_valid,
  input logic in_ready,
  input logic err_short,
  input logic err_underrun,
  input logic bclk_fall,
  input logic started,
  input logic left_start,
  input logic hold_full
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (sdata == 1'b0)); // R1

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata != $past(sdata)) |-> $past(bclk_fall)); // R10

  AST_TAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R7

  AST_UNDERRUN_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (left_start && !hold_full) |=> err_underrun); // R9

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_underrun |=> err_underrun); // R9

  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_short |=> err_short); // R6

endmodule

bind i2s_slave_tx i2s_slave_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sdata       (sdata),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .err_short   (err_short),
  .err_underrun(err_underrun),
  .bclk_fall   (bclk_fall),
  .started     (started),
  .left_start  (left_start),
  .hold_full   (hold_full)
);

// File: tb/i2s_slave_tx_tb.sv
`timescale 1ns/1ps
module i2s_slave_tx_tb;
  localparam int W    = 16;
  localparam int HALF = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bclk = 1'b1;
  logic         ws = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_left = '0;
  logic [W-1:0] in_right = '0;
  logic         sdata;
  logic         in_ready;
  logic         err_short;
  logic         err_underrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [2*W-1:0] pq[$];
  bit             m_started = 1'b0;
  bit             m_short = 1'b0;
  bit             m_underrun = 1'b0;
  logic [W-1:0]   m_sl = '0;
  logic [W-1:0]   m_sr = '0;
  logic [W-1:0]   m_cur_word = '0;
  int             m_cur_len = 0;
  logic [W-1:0]   m_prev_word = '0;
  int             m_prev_len = 0;

  always #4 clk = ~clk;

  i2s_slave_tx #(.WORD_W(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .ws(ws), .sdata(sdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
    .in_right(in_right), .err_short(err_short), .err_underrun(err_underrun)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic bitval(logic [W-1:0] w, int idx);
    if (idx >= 1 && idx <= W) return w[W-idx];
    return 1'b0;
  endfunction

  task automatic push(logic [W-1:0] l, logic [W-1:0] r);
    @(posedge clk); #1;
    in_valid = 1'b1; in_left = l; in_right = r;
    while (!in_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 1'b0;
    pq.push_back({l, r});
    chk(in_ready == 1'b0, "R7", "in_ready after transfer", in_ready, 0);
  endtask

  task automatic model_edge(bit wsv, int len);
    logic [2*W-1:0] p;
    if (m_started) begin
      if (m_cur_len < W + 1) m_short = 1'b1;
      m_prev_word = m_cur_word;
      m_prev_len  = m_cur_len;
    end else begin
      m_prev_len = 0;
    end
    if (!m_started && !wsv) m_started = 1'b1;
    if (m_started) begin
      if (!wsv) begin
        if (pq.size() > 0) begin
          p = pq.pop_front();
          m_sl = p[2*W-1:W];
          m_sr = p[W-1:0];
        end else begin
          m_underrun = 1'b1;
        end
        m_cur_word = m_sl;
      end else begin
        m_cur_word = m_sr;
      end
    end
    m_cur_len = len;
  endtask

  // One slot of the master: len bit clocks, word select wsv set at the first fall.
  task automatic run_slot(int len, bit wsv, string tag, bit do_push,
                          logic [W-1:0] pl, logic [W-1:0] pr);
    for (int k = 0; k < len; k++) begin
      logic exp_b;
      logic got;
      string t;
      bclk = 1'b0;
      if (k == 0) begin
        if (ws != wsv) model_edge(wsv, len);
        else if (m_started) m_cur_len = m_cur_len + len;
        ws = wsv;
      end
      if (!m_started) begin
        exp_b = 1'b0; t = "R1";
      end else if (k == 0) begin
        exp_b = bitval(m_prev_word, m_prev_len); t = "R2";
      end else begin
        exp_b = bitval(m_cur_word, k);
        if (k > W) t = "R4";
        else if (k == 1 && wsv) t = "R5";
        else t = tag;
      end
      repeat (HALF) @(posedge clk); #1;
      got = sdata;
      chk(got == exp_b, t, $sformatf("sdata bit %0d of %0d-bit slot", k, len),
          int'(got), int'(exp_b));
      if (k == 2) begin
        chk(err_short == m_short, "R6", "err_short", err_short, m_short);
        chk(err_underrun == m_underrun, "R9", "err_underrun", err_underrun, m_underrun);
        chk(in_ready == (pq.size() == 0), "R7", "in_ready", in_ready, int'(pq.size() == 0));
      end
      bclk = 1'b1;
      repeat (HALF) @(posedge clk); #1;
      chk(sdata == got, "R10", "sdata held through high phase", sdata, got);
      if (do_push && k == 8) push(pl, pr);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk(sdata == 1'b0, "R1", "sdata after reset", sdata, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(err_short == 1'b0, "R1", "err_short after reset", err_short, 0);
    chk(err_underrun == 1'b0, "R1", "err_underrun after reset", err_underrun, 0);

    push(16'hA55A, 16'h3C96);
    run_slot(7, 1'b1, "R1", 1'b0, '0, '0);
    run_slot(21, 1'b0, "R8", 1'b0, '0, '0);
    run_slot(21, 1'b1, "R3", 1'b1, 16'h8001, 16'h7FFE);
    run_slot(32, 1'b0, "R3", 1'b0, '0, '0);
    run_slot(32, 1'b1, "R3", 1'b1, 16'hFFFF, 16'h0000);
    run_slot(17, 1'b0, "R8", 1'b0, '0, '0);
    run_slot(17, 1'b1, "R8", 1'b0, '0, '0);
    run_slot(21, 1'b0, "R9", 1'b0, '0, '0);
    run_slot(21, 1'b1, "R9", 1'b1, 16'h1234, 16'hEDCB);
    run_slot(12, 1'b0, "R6", 1'b0, '0, '0);
    run_slot(21, 1'b1, "R6", 1'b1, 16'h0F0F, 16'hC3C3);
    run_slot(21, 1'b0, "R3", 1'b0, '0, '0);
    run_slot(16, 1'b1, "R6", 1'b0, '0, '0);
    run_slot(21, 1'b0, "R2", 1'b0, '0, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule